// File: doc/BRIEF.md
# Split 64-bit shifted pointer adder

This block forms a 64-bit sum from two 32-bit halves in two pipeline stages. It is meant for address arithmetic: a base pointer (`src1`) gets an offset (`src2`) added after the offset is moved left by a small immediate of 0 to 7 bit positions. The offset is either a full 64-bit value, or a 32-bit value that is widened to 64 bits with zero-extension or sign-extension before it is shifted.

The low stage adds the low words. It sends a private sideband bundle to the high stage. The bundle holds the carry, the bits pushed out of the top of the offset's low word, the shift amount, the offset's sign and the mode. The high stage uses this bundle to build its own offset word and finishes the upper 32 bits. In the 32-bit modes the high stage never reads the offset's high word. Each stage registers its result together with a valid flag. Both halves of the result leave the block on the same cycle.

Top module: `split_ptr_adder`

## Requirements
- R1: `out_valid` is asserted exactly two clock cycles after a cycle with `in_valid` high, and is low otherwise. `out_lo` and `out_hi` keep their last values while no new result arrives.
- R2: With mode 2'b00 (wide), the result {`out_hi`,`out_lo`} equals {`src1_hi`,`src1_lo`} + ({`src2_hi`,`src2_lo`} << `in_shamt`), modulo 2^64.
- R3: With mode 2'b01 (zero-extend), the result equals the 64-bit src1 plus (`src2_lo` zero-extended to 64 bits) << `in_shamt`, modulo 2^64.
- R4: With mode 2'b10 (sign-extend), the result equals the 64-bit src1 plus (`src2_lo` sign-extended from bit 31 to 64 bits) << `in_shamt`, modulo 2^64.
- R5: Mode 2'b11 gives the same result as mode 2'b00.
- R6: In modes 2'b01 and 2'b10 the value on `src2_hi` has no effect on the result.
- R7: The shift of 0 to 7 is applied to the offset before the addition. Bits that leave the top of `src2_lo` appear in the high half of the result.
- R8: A carry out of bit 31 of the sum reaches the high half. A carry out of bit 63 is dropped.
- R9: While `rst` is high at a clock edge, the pipeline is cleared. On the next cycle `out_valid`, `out_lo` and `out_hi` are all zero.
- R10: Operations issued on consecutive cycles each produce their own correct result, one per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_mode | input | 2 | 00 wide, 01 zero-extend, 10 sign-extend, 11 wide |
| in_shamt | input | 3 | Left shift applied to the offset, 0 to 7 |
| src1_lo | input | 32 | Base pointer, low word |
| src1_hi | input | 32 | Base pointer, high word |
| src2_lo | input | 32 | Offset, low word (the whole offset in 32-bit modes) |
| src2_hi | input | 32 | Offset, high word (used in wide mode only) |
| out_valid | output | 1 | Result present |
| out_lo | output | 32 | Result, low word |
| out_hi | output | 32 | Result, high word |

## Verification
The assertions assume that `in_valid` and the operand inputs are driven to known values on every clock edge outside reset. They also assume that the shift input never holds an unknown value, because the spill and sign-fill checks reason about the shift amount. The bench drives every input on the falling edge from fully specified constants or `$urandom` values, including idle and reset cycles. This keeps the design inside those assumptions while the shift, the mode and the carry patterns are swept.

// File: rtl/ptradd_pkg.sv
package ptradd_pkg;
  parameter int HALF_W  = 32;
  parameter int SHAMT_W = 3;
  localparam int SPILL_W = (1 << SHAMT_W) - 1;
  localparam int FULL_W  = 2 * HALF_W;

  typedef enum logic [1:0] {
    MODE_WIDE     = 2'b00,
    MODE_ZEXT     = 2'b01,
    MODE_SEXT     = 2'b10,
    MODE_WIDE_ALT = 2'b11
  } add_mode_e;

  // Private link from the low stage to the high stage
  typedef struct packed {
    logic                carry;
    logic [SPILL_W-1:0]  spill;
    logic [SHAMT_W-1:0]  shamt;
    logic                sign;
    add_mode_e           mode;
  } sideband_t;
endpackage

// File: rtl/ptradd_word_add.sv
module ptradd_word_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
  end
endmodule

// File: rtl/ptradd_lo_stage.sv
module ptradd_lo_stage
  import ptradd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  add_mode_e          in_mode,
  input  logic [SHAMT_W-1:0] in_shamt,
  input  logic [HALF_W-1:0]  a_lo,
  input  logic [HALF_W-1:0]  a_hi,
  input  logic [HALF_W-1:0]  b_lo,
  input  logic [HALF_W-1:0]  b_hi,
  output logic               s1_valid,
  output logic [HALF_W-1:0]  s1_sum_lo,
  output logic [HALF_W-1:0]  s1_a_hi,
  output logic [HALF_W-1:0]  s1_b_hi,
  output sideband_t          s1_sb
);
  logic [FULL_W-1:0] shifted;
  logic [HALF_W-1:0] shifted_lo;
  logic [HALF_W-1:0] sum_lo_c;
  logic              carry_c;
  sideband_t         sb_c;

  always_comb begin
    shifted    = {{HALF_W{1'b0}}, b_lo} << in_shamt;
    shifted_lo = shifted[HALF_W-1:0];
  end

  ptradd_word_add #(.W(HALF_W)) lo_add_i (
    .op_a (a_lo),
    .op_b (shifted_lo),
    .cin  (1'b0),
    .sum  (sum_lo_c),
    .cout (carry_c)
  );

  always_comb begin
    sb_c.carry = carry_c;
    sb_c.spill = shifted[HALF_W +: SPILL_W];
    sb_c.shamt = in_shamt;
    sb_c.sign  = b_lo[HALF_W-1];
    sb_c.mode  = in_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_sum_lo <= '0;
      s1_a_hi   <= '0;
      s1_b_hi   <= '0;
      s1_sb     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sum_lo <= sum_lo_c;
        s1_a_hi   <= a_hi;
        s1_b_hi   <= b_hi;
        s1_sb     <= sb_c;
      end
    end
  end
endmodule

// File: rtl/ptradd_hi_stage.sv
module ptradd_hi_stage
  import ptradd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [HALF_W-1:0] s1_sum_lo,
  input  logic [HALF_W-1:0] s1_a_hi,
  input  logic [HALF_W-1:0] s1_b_hi,
  input  sideband_t         s1_sb,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_lo,
  output logic [HALF_W-1:0] out_hi
);
  logic [HALF_W-1:0] spill_word;
  logic [HALF_W-1:0] wide_word;
  logic [HALF_W-1:0] fill_word;
  logic [HALF_W-1:0] hi_operand;
  logic [HALF_W-1:0] sum_hi_c;
  logic              carry_top;

  always_comb begin
    spill_word = {{(HALF_W-SPILL_W){1'b0}}, s1_sb.spill};
    wide_word  = (s1_b_hi << s1_sb.shamt) | spill_word;
    fill_word  = ({HALF_W{s1_sb.sign}} << s1_sb.shamt) | spill_word;
    unique case (s1_sb.mode)
      MODE_ZEXT: hi_operand = spill_word;
      MODE_SEXT: hi_operand = fill_word;
      default:   hi_operand = wide_word;
    endcase
  end

  ptradd_word_add #(.W(HALF_W)) hi_add_i (
    .op_a (s1_a_hi),
    .op_b (hi_operand),
    .cin  (s1_sb.carry),
    .sum  (sum_hi_c),
    .cout (carry_top)
  );

  logic unused_top;
  assign unused_top = carry_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_lo <= s1_sum_lo;
        out_hi <= sum_hi_c;
      end
    end
  end
endmodule

// File: rtl/split_ptr_adder.sv
module split_ptr_adder
  import ptradd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_mode,
  input  logic [SHAMT_W-1:0] in_shamt,
  input  logic [HALF_W-1:0]  src1_lo,
  input  logic [HALF_W-1:0]  src1_hi,
  input  logic [HALF_W-1:0]  src2_lo,
  input  logic [HALF_W-1:0]  src2_hi,
  output logic               out_valid,
  output logic [HALF_W-1:0]  out_lo,
  output logic [HALF_W-1:0]  out_hi
);
  logic              s1_valid;
  logic [HALF_W-1:0] s1_sum_lo;
  logic [HALF_W-1:0] s1_a_hi;
  logic [HALF_W-1:0] s1_b_hi;
  sideband_t         s1_sb;

  ptradd_lo_stage lo_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (add_mode_e'(in_mode)),
    .in_shamt  (in_shamt),
    .a_lo      (src1_lo),
    .a_hi      (src1_hi),
    .b_lo      (src2_lo),
    .b_hi      (src2_hi),
    .s1_valid  (s1_valid),
    .s1_sum_lo (s1_sum_lo),
    .s1_a_hi   (s1_a_hi),
    .s1_b_hi   (s1_b_hi),
    .s1_sb     (s1_sb)
  );

  ptradd_hi_stage hi_i (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_sum_lo (s1_sum_lo),
    .s1_a_hi   (s1_a_hi),
    .s1_b_hi   (s1_b_hi),
    .s1_sb     (s1_sb),
    .out_valid (out_valid),
    .out_lo    (out_lo),
    .out_hi    (out_hi)
  );
endmodule

// File: rtl/ptradd_checker.sv
module ptradd_checker
  import ptradd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              s1_valid,
  input logic [HALF_W-1:0] s1_a_hi,
  input sideband_t         s1_sb,
  input logic              out_valid,
  input logic [HALF_W-1:0] out_lo,
  input logic [HALF_W-1:0] out_hi
);
  assert_stage1_valid_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  assert_stage1_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid);
  assert_stage2_valid_R10: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> ($stable(out_lo) && $stable(out_hi) && !out_valid));
  assert_spill_bound_R7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> ((s1_sb.spill >> s1_sb.shamt) == '0));
  assert_zext_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_sb.mode == MODE_ZEXT && s1_sb.shamt == '0)
      |=> out_hi == $past(s1_a_hi) + {{(HALF_W-1){1'b0}}, $past(s1_sb.carry)});
  assert_sext_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_sb.mode == MODE_SEXT && s1_sb.shamt == '0 && s1_sb.sign && !s1_sb.carry)
      |=> out_hi == $past(s1_a_hi) - {{(HALF_W-1){1'b0}}, 1'b1});
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && !s1_valid && out_lo == '0 && out_hi == '0));
endmodule

bind split_ptr_adder ptradd_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .s1_a_hi   (s1_a_hi),
  .s1_sb     (s1_sb),
  .out_valid (out_valid),
  .out_lo    (out_lo),
  .out_hi    (out_hi)
);

// File: tb/split_ptr_adder_tb_top.sv
`timescale 1ns/1ps
module split_ptr_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic [2:0]  in_shamt = 3'd0;
  logic [31:0] src1_lo = '0, src1_hi = '0, src2_lo = '0, src2_hi = '0;
  logic        out_valid;
  logic [31:0] out_lo, out_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural pipeline model
  bit          m1_v = 0, m2_v = 0;
  logic [63:0] m1_sum = '0, m2_sum = '0;
  string       m1_tag = "R9", m2_tag = "R9";

  always #4 clk = ~clk;

  split_ptr_adder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_shamt(in_shamt),
    .src1_lo(src1_lo), .src1_hi(src1_hi), .src2_lo(src2_lo), .src2_hi(src2_hi),
    .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi)
  );

  function automatic logic [63:0] ref_sum(input logic [1:0] m, input int sh,
                                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] off;
    case (m)
      2'b01:   off = {32'h0, b[31:0]};
      2'b10:   off = {{32{b[31]}}, b[31:0]};
      default: off = b;
    endcase
    return a + (off << sh);
  endfunction

  task automatic cycle(input bit r, input bit v, input logic [1:0] m, input int sh,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    rst = r; in_valid = v; in_mode = m; in_shamt = sh[2:0];
    src1_lo = a[31:0]; src1_hi = a[63:32]; src2_lo = b[31:0]; src2_hi = b[63:32];
    @(posedge clk);
    if (r) begin
      m1_v = 0; m2_v = 0; m1_sum = '0; m2_sum = '0; m1_tag = "R9"; m2_tag = "R9";
    end else begin
      if (m1_v) m2_sum = m1_sum;
      m2_v = m1_v;
      m2_tag = m1_v ? m1_tag : (m2_tag == "R9" ? "R9" : "R1 hold");
      m1_v = v;
      if (v) begin m1_sum = ref_sum(m, sh, a, b); m1_tag = tag; end
    end
    @(negedge clk);
    checks++;
    if (out_valid !== m2_v || {out_hi, out_lo} !== m2_sum) begin
      fails++;
      $display("FAIL %s: got valid=%0b sum=%h, expected valid=%0b sum=%h",
               m2_tag, out_valid, {out_hi, out_lo}, m2_v, m2_sum);
    end
  endtask

  task automatic op(input logic [1:0] m, input int sh, input logic [63:0] a,
                    input logic [63:0] b, input string tag);
    cycle(0, 1, m, sh, a, b, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 2'b00, 0, 64'hDEAD_BEEF_0BAD_F00D, 64'h1234, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: reset state, with in_valid held high during reset
    for (int i = 0; i < 3; i++) cycle(1, 1, 2'b00, 1, 64'h5, 64'h7, "R9");
    idle(2);
    // R2 wide mode
    op(2'b00, 0, 64'h0000_0001_0000_0002, 64'h0000_0003_0000_0004, "R2");
    op(2'b00, 3, 64'h1111_2222_3333_4444, 64'h0F0F_0F0F_F0F0_F0F0, "R2");
    idle(2);
    // R7: shift sweep with full low word spilling
    for (int s = 0; s < 8; s++) op(2'b00, s, 64'h0, 64'h0000_0000_FFFF_FFFF, "R7");
    for (int s = 0; s < 8; s++) op(2'b01, s, 64'h10, 64'h8000_0001, "R7");
    // R3 / R4
    op(2'b01, 2, 64'h0000_0005_0000_0000, 64'hFFFF_FFFF_C000_0000, "R3");
    op(2'b10, 0, 64'h0000_0005_0000_0000, 64'h0000_0000_FFFF_FFFF, "R4");
    op(2'b10, 7, 64'h0000_0100_0000_0000, 64'h0000_0000_8000_0000, "R4");
    op(2'b10, 1, 64'h0, 64'h0000_0000_7FFF_FFFF, "R4");
    // R5
    op(2'b11, 5, 64'hAAAA_5555_1234_5678, 64'h0123_4567_89AB_CDEF, "R5");
    // R6: same op, different src2_hi
    op(2'b01, 4, 64'h9, 64'h0000_0000_F000_0001, "R6");
    op(2'b01, 4, 64'h9, 64'hFFFF_FFFF_F000_0001, "R6");
    op(2'b10, 4, 64'h9, 64'h5A5A_5A5A_F000_0001, "R6");
    op(2'b10, 4, 64'h9, 64'hA5A5_A5A5_F000_0001, "R6");
    // R8: carry into high half and wrap beyond bit 63
    op(2'b00, 0, 64'h0000_0000_FFFF_FFFF, 64'h1, "R8");
    op(2'b00, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R8");
    op(2'b10, 0, 64'h0, 64'h0000_0000_FFFF_FFFF, "R8");
    idle(3);
    // R10: back-to-back random traffic
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      op(2'($urandom), int'($urandom % 8), a, b, "R10");
      if (i % 37 == 36) idle(1);
    end
    // R9 mid-stream reset
    op(2'b00, 1, 64'h77, 64'h88, "R10");
    cycle(1, 1, 2'b00, 1, 64'h1, 64'h1, "R9");
    idle(3);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule